// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit logical address into a physical address by walking a two-level table held in memory. The page offset is 10 bits, so pages are 1 KB. The 22-bit page number above the offset is split into a 12-bit outer index in bits 31:20 and a 10-bit inner index in bits 19:10. The outer index picks an entry in the outer table. That entry locates the inner table. The inner index then picks the leaf entry, which gives the frame of the page.

A requester hands over one address at a time through a valid/ready pair. The answer comes back as a one-cycle response pulse carrying either the physical address or a fault code. Table reads go out on a memory port that allows one outstanding read. The request on that port uses a valid/ready handshake, and the data returns with a separate valid strobe. Software programs two registers through a small write port: the byte address of the outer table and the number of outer entries that are legal.

Top module: `ptw_two_level`

## Requirements
- R1: A walk that finds both entries valid, and has write permission when the access is a write, responds with fault code 0 and a physical address made of the leaf entry's bits 31:10 above the logical address bits 9:0.
- R2: The outer entry is read at byte address table_base + 4 * vaddr[31:20]. The inner entry is read at {outer_entry[31:10], 10'b0} + 4 * vaddr[19:10]. A successful walk makes exactly these two reads, in this order.
- R3: When the outer index is at or above the programmed length, the walker responds with fault code 1 and issues no memory read.
- R4: When an outer entry has bit 0 (valid) clear, the walker responds with fault code 2 after that single read and makes no inner read.
- R5: When a leaf entry has bit 0 clear, the walker responds with fault code 3.
- R6: A write access (req_write=1) to a leaf whose bit 1 (writable) is clear responds with fault code 4. A read access to the same page succeeds, and a write access to a page with bit 1 set also succeeds.
- R7: req_ready is low from the cycle after a request is accepted until the cycle after the response. resp_valid lasts exactly one cycle, and req_ready is high again in the cycle after it.
- R8: A memory request holds mem_req_valid and mem_addr steady until mem_req_ready is seen. The walker waits any number of cycles for mem_rsp_valid. With a stall of s cycles before each accept and a response latency of L extra cycles, a full walk responds 5 + 2(s + L) cycles after the request is accepted.
- R9: A configuration write with cfg_sel=0 sets the table base, and one with cfg_sel=1 sets the length from cfg_wdata[12:0]. A write made during a walk does not change that walk. It applies to requests accepted afterwards.
- R10: After reset, req_ready=1, resp_valid=0, mem_req_valid=0, and the table base and length are 0. A request made before any configuration therefore faults with code 1.
- R11: Every faulting response carries a physical address of 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 1 | 0 selects the table base, 1 selects the length |
| cfg_wdata | input | 32 | Configuration write data |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle and able to accept a request |
| req_vaddr | input | 32 | Logical address to translate |
| req_write | input | 1 | Access is a write |
| resp_valid | output | 1 | One-cycle response strobe |
| resp_paddr | output | 32 | Physical address, 0 on a fault |
| resp_fault | output | 3 | 0 ok, 1 length, 2 outer invalid, 3 inner invalid, 4 write to read-only |
| mem_req_valid | output | 1 | Table read request |
| mem_req_ready | input | 1 | Memory accepts the read request |
| mem_addr | output | 32 | Byte address of the table entry |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 32 | Table entry read |

## Verification
The bench targets the edges of the index fields and of the length check. It uses outer index 7 against a length of 8 and inner index 1023 with offset 0x3FF, where a wrong field split or a shift that drops a bit produces the wrong read address or frame. Outer index 8 against a length of 8 must fault without a single read; an off-by-one compare would either walk or fault one index too early. Each fault type is checked by counting the reads made: a walker that keeps going after an invalid outer entry shows up as an extra read. A write-permission check applied to reads shows up as a spurious code 4. Stalled and slow memory, together with configuration writes made during a walk, catch a walker that drops a request before it is accepted, takes stale data, or reads the live registers in the middle of a walk.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

  typedef enum logic [2:0] {
    FLT_NONE  = 3'd0,
    FLT_LEN   = 3'd1,
    FLT_OUTER = 3'd2,
    FLT_INNER = 3'd3,
    FLT_WPROT = 3'd4
  } ptw_fault_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_OUTER,
    ST_INNER,
    ST_DONE,
    ST_FAULT
  } ptw_state_e;

  localparam int PTE_VALID_BIT = 0;
  localparam int PTE_WRITE_BIT = 1;

endpackage

// File: rtl/ptw_cfg_regs.sv
module ptw_cfg_regs #(
  parameter int PA_W  = 32,
  parameter int LEN_W = 13
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_we,
  input  logic             cfg_sel,
  input  logic [PA_W-1:0]  cfg_wdata,
  output logic [PA_W-1:0]  base_o,
  output logic [LEN_W-1:0] len_o
);

  always_ff @(posedge clk) begin
    if (rst) begin
      base_o <= '0;
      len_o  <= '0;
    end else if (cfg_we) begin
      if (cfg_sel) len_o  <= cfg_wdata[LEN_W-1:0];
      else         base_o <= cfg_wdata;
    end
  end

endmodule

// File: rtl/ptw_addr_calc.sv
module ptw_addr_calc #(
  parameter int VA_W      = 32,
  parameter int PA_W      = 32,
  parameter int OFF_W     = 10,
  parameter int IN_W      = 10,
  parameter int ENT_SHIFT = 2
) (
  input  logic [VA_W-OFF_W-IN_W-1:0] outer_idx_i,
  input  logic [PA_W-1:0]            base_i,
  input  logic [VA_W-OFF_W-IN_W:0]   len_i,
  input  logic [OFF_W+IN_W-1:0]      va_low_i,
  input  logic [PA_W-OFF_W-1:0]      frame_i,
  output logic [PA_W-1:0]            outer_addr_o,
  output logic                       len_fault_o,
  output logic [PA_W-1:0]            inner_addr_o,
  output logic [PA_W-1:0]            leaf_paddr_o
);

  localparam int OUT_W = VA_W - OFF_W - IN_W;

  logic [IN_W-1:0]  inner_idx;
  logic [OFF_W-1:0] page_off;

  assign inner_idx = va_low_i[OFF_W+IN_W-1:OFF_W];
  assign page_off  = va_low_i[OFF_W-1:0];

  always_comb begin
    outer_addr_o = base_i + (PA_W'(outer_idx_i) << ENT_SHIFT);
    len_fault_o  = ({1'b0, outer_idx_i} >= len_i);
    inner_addr_o = {frame_i, {OFF_W{1'b0}}} + (PA_W'(inner_idx) << ENT_SHIFT);
    leaf_paddr_o = {frame_i, page_off};
  end

  // Width sanity for the derived outer field
  initial begin
    if (OUT_W < 1) $display("ptw_addr_calc: outer index width must be positive");
  end

endmodule

// File: rtl/ptw_walk_ctrl.sv
module ptw_walk_ctrl
  import ptw_pkg::*;
#(
  parameter int PA_W  = 32,
  parameter int LOW_W = 20
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [LOW_W-1:0] req_va_low,
  input  logic             req_write,
  input  logic             len_fault,
  input  logic [PA_W-1:0]  outer_addr,
  input  logic [PA_W-1:0]  inner_addr,
  input  logic [PA_W-1:0]  leaf_paddr,
  output logic [LOW_W-1:0] va_low_q,
  output logic             resp_valid,
  output logic [PA_W-1:0]  resp_paddr,
  output logic [2:0]       resp_fault,
  output logic             mem_req_valid,
  input  logic             mem_req_ready,
  output logic [PA_W-1:0]  mem_addr,
  input  logic             mem_rsp_valid,
  input  logic             pte_valid,
  input  logic             pte_write
);

  ptw_state_e state_q;
  ptw_fault_e code_q;
  logic       wr_q;
  logic       rsp_take;

  assign req_ready  = (state_q == ST_IDLE);
  assign resp_fault = code_q;
  // data counts only once the request has been handed over
  assign rsp_take   = mem_rsp_valid && !mem_req_valid;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q       <= ST_IDLE;
      code_q        <= FLT_NONE;
      wr_q          <= 1'b0;
      va_low_q      <= '0;
      resp_valid    <= 1'b0;
      resp_paddr    <= '0;
      mem_req_valid <= 1'b0;
      mem_addr      <= '0;
    end else begin
      resp_valid <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (req_valid) begin
            va_low_q <= req_va_low;
            wr_q     <= req_write;
            if (len_fault) begin
              code_q     <= FLT_LEN;
              resp_paddr <= '0;
              resp_valid <= 1'b1;
              state_q    <= ST_FAULT;
            end else begin
              mem_addr      <= outer_addr;
              mem_req_valid <= 1'b1;
              state_q       <= ST_OUTER;
            end
          end
        end
        ST_OUTER: begin
          if (mem_req_valid && mem_req_ready) begin
            mem_req_valid <= 1'b0;
          end else if (rsp_take) begin
            if (!pte_valid) begin
              code_q     <= FLT_OUTER;
              resp_paddr <= '0;
              resp_valid <= 1'b1;
              state_q    <= ST_FAULT;
            end else begin
              mem_addr      <= inner_addr;
              mem_req_valid <= 1'b1;
              state_q       <= ST_INNER;
            end
          end
        end
        ST_INNER: begin
          if (mem_req_valid && mem_req_ready) begin
            mem_req_valid <= 1'b0;
          end else if (rsp_take) begin
            resp_valid <= 1'b1;
            if (!pte_valid) begin
              code_q     <= FLT_INNER;
              resp_paddr <= '0;
              state_q    <= ST_FAULT;
            end else if (wr_q && !pte_write) begin
              code_q     <= FLT_WPROT;
              resp_paddr <= '0;
              state_q    <= ST_FAULT;
            end else begin
              code_q     <= FLT_NONE;
              resp_paddr <= leaf_paddr;
              state_q    <= ST_DONE;
            end
          end
        end
        ST_DONE, ST_FAULT: state_q <= ST_IDLE;
        default:           state_q <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/ptw_two_level.sv
module ptw_two_level
  import ptw_pkg::*;
#(
  parameter int VA_W      = 32,
  parameter int PA_W      = 32,
  parameter int OFF_W     = 10,
  parameter int IN_W      = 10,
  parameter int ENT_BYTES = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            cfg_we,
  input  logic            cfg_sel,
  input  logic [PA_W-1:0] cfg_wdata,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic [VA_W-1:0] req_vaddr,
  input  logic            req_write,
  output logic            resp_valid,
  output logic [PA_W-1:0] resp_paddr,
  output logic [2:0]      resp_fault,
  output logic            mem_req_valid,
  input  logic            mem_req_ready,
  output logic [PA_W-1:0] mem_addr,
  input  logic            mem_rsp_valid,
  input  logic [PA_W-1:0] mem_rsp_data
);

  localparam int OUT_W     = VA_W - OFF_W - IN_W;
  localparam int LEN_W     = OUT_W + 1;
  localparam int LOW_W     = OFF_W + IN_W;
  localparam int FRM_W     = PA_W - OFF_W;
  localparam int ENT_SHIFT = $clog2(ENT_BYTES);

  logic [PA_W-1:0]  cfg_base;
  logic [LEN_W-1:0] cfg_len;
  logic [PA_W-1:0]  outer_addr, inner_addr, leaf_paddr;
  logic             len_fault;
  logic [LOW_W-1:0] va_low_q;
  logic             rsvd_unused;

  assign rsvd_unused = ^mem_rsp_data[OFF_W-1:PTE_WRITE_BIT+1];

  ptw_cfg_regs #(.PA_W(PA_W), .LEN_W(LEN_W)) u_cfg (
    .clk       (clk),
    .rst       (rst),
    .cfg_we    (cfg_we),
    .cfg_sel   (cfg_sel),
    .cfg_wdata (cfg_wdata),
    .base_o    (cfg_base),
    .len_o     (cfg_len)
  );

  ptw_addr_calc #(
    .VA_W(VA_W), .PA_W(PA_W), .OFF_W(OFF_W), .IN_W(IN_W), .ENT_SHIFT(ENT_SHIFT)
  ) u_calc (
    .outer_idx_i  (req_vaddr[VA_W-1 -: OUT_W]),
    .base_i       (cfg_base),
    .len_i        (cfg_len),
    .va_low_i     (va_low_q),
    .frame_i      (mem_rsp_data[PA_W-1 -: FRM_W]),
    .outer_addr_o (outer_addr),
    .len_fault_o  (len_fault),
    .inner_addr_o (inner_addr),
    .leaf_paddr_o (leaf_paddr)
  );

  ptw_walk_ctrl #(.PA_W(PA_W), .LOW_W(LOW_W)) u_ctrl (
    .clk           (clk),
    .rst           (rst),
    .req_valid     (req_valid),
    .req_ready     (req_ready),
    .req_va_low    (req_vaddr[LOW_W-1:0]),
    .req_write     (req_write),
    .len_fault     (len_fault),
    .outer_addr    (outer_addr),
    .inner_addr    (inner_addr),
    .leaf_paddr    (leaf_paddr),
    .va_low_q      (va_low_q),
    .resp_valid    (resp_valid),
    .resp_paddr    (resp_paddr),
    .resp_fault    (resp_fault),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_addr      (mem_addr),
    .mem_rsp_valid (mem_rsp_valid),
    .pte_valid     (mem_rsp_data[PTE_VALID_BIT]),
    .pte_write     (mem_rsp_data[PTE_WRITE_BIT])
  );

endmodule

// File: rtl/ptw_two_level_chk.sv
module ptw_two_level_chk #(
  parameter int VA_W  = 32,
  parameter int PA_W  = 32,
  parameter int OUT_W = 12
) (
  input logic            clk,
  input logic            rst,
  input logic            req_valid,
  input logic            req_ready,
  input logic [VA_W-1:0] req_vaddr,
  input logic            resp_valid,
  input logic [PA_W-1:0] resp_paddr,
  input logic [2:0]      resp_fault,
  input logic            mem_req_valid,
  input logic            mem_req_ready,
  input logic [PA_W-1:0] mem_addr,
  input logic [OUT_W:0]  len_q
);

  AST_LEN_NO_READ: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready && ({1'b0, req_vaddr[VA_W-1 -: OUT_W]} >= len_q))
      |=> (resp_valid && resp_fault == 3'd1 && !mem_req_valid)); // R3

  AST_MEM_HOLD: assert property (@(posedge clk) disable iff (rst)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_addr))); // R8

  AST_RESP_PULSE: assert property (@(posedge clk) disable iff (rst)
    resp_valid |=> (!resp_valid && req_ready)); // R7

  AST_BUSY_NO_ACCEPT: assert property (@(posedge clk) disable iff (rst)
    (mem_req_valid || resp_valid) |-> !req_ready); // R7

  AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> !req_ready); // R7

  AST_FAULT_ZERO_PA: assert property (@(posedge clk) disable iff (rst)
    (resp_valid && resp_fault != 3'd0) |-> (resp_paddr == '0)); // R11

  AST_CODE_RANGE: assert property (@(posedge clk) disable iff (rst)
    resp_valid |-> (resp_fault <= 3'd4)); // R1

endmodule

bind ptw_two_level ptw_two_level_chk #(
  .VA_W(VA_W), .PA_W(PA_W), .OUT_W(VA_W - OFF_W - IN_W)
) u_chk (
  .clk           (clk),
  .rst           (rst),
  .req_valid     (req_valid),
  .req_ready     (req_ready),
  .req_vaddr     (req_vaddr),
  .resp_valid    (resp_valid),
  .resp_paddr    (resp_paddr),
  .resp_fault    (resp_fault),
  .mem_req_valid (mem_req_valid),
  .mem_req_ready (mem_req_ready),
  .mem_addr      (mem_addr),
  .len_q         (cfg_len)
);

// File: tb/ptw_two_level_test.sv
`timescale 1ns/1ps
module ptw_two_level_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0, cfg_sel = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [31:0] req_vaddr = '0;
  logic        req_ready, resp_valid, mem_req_valid;
  logic [31:0] resp_paddr, mem_addr;
  logic [2:0]  resp_fault;
  logic        mem_req_ready = 1'b0, mem_rsp_valid = 1'b0;
  logic [31:0] mem_rsp_data = '0;

  int n_checks = 0, n_fail = 0;
  bit done = 1'b0;

  // memory model state
  logic [31:0] tbl [logic [31:0]];
  logic [31:0] rd_q [$];
  int stall_cfg = 0, lat_cfg = 0, wait_ctr = 0, pend_cnt = 0;
  bit pend = 1'b0;
  logic [31:0] pend_addr = '0;

  always #2.5 clk = ~clk;

  ptw_two_level uut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr), .req_write(req_write),
    .resp_valid(resp_valid), .resp_paddr(resp_paddr), .resp_fault(resp_fault),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_addr(mem_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // memory responder: one outstanding read, configurable stall and latency
  initial begin
    forever begin
      @(negedge clk);
      mem_rsp_valid = 1'b0;
      if (pend) begin
        if (pend_cnt == 0) begin
          mem_rsp_valid = 1'b1;
          mem_rsp_data  = tbl.exists(pend_addr) ? tbl[pend_addr] : 32'h0;
          pend = 1'b0;
        end else pend_cnt--;
      end
      mem_req_ready = mem_req_valid && (wait_ctr >= stall_cfg);
      if (mem_req_valid && mem_req_ready && !pend) begin
        pend = 1'b1; pend_addr = mem_addr; pend_cnt = lat_cfg; wait_ctr = 0;
        rd_q.push_back(mem_addr);
      end else if (mem_req_valid) wait_ctr++;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  task automatic cfg_write(input logic sel, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // issues one translation; poke writes length 0 and a new base mid-walk
  task automatic xlate(input logic [31:0] va, input logic wr, input bit poke,
                       output logic [31:0] pa, output logic [2:0] code, output int cyc);
    int n = 0;
    rd_q.delete();
    @(negedge clk);
    req_valid = 1'b1; req_vaddr = va; req_write = wr;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    n = 1;
    req_valid = 1'b0;
    while (!resp_valid && n < 400) begin
      if (req_ready) chk("R7 busy ready", 32'(req_ready), 32'd0);
      if (poke && n == 1) begin cfg_we = 1'b1; cfg_sel = 1'b1; cfg_wdata = 32'h0; end
      else if (poke && n == 2) begin cfg_we = 1'b1; cfg_sel = 1'b0; cfg_wdata = 32'h0009_0000; end
      else cfg_we = 1'b0;
      @(negedge clk);
      n++;
    end
    cfg_we = 1'b0;
    pa = resp_paddr; code = resp_fault; cyc = n;
    @(negedge clk);
    chk("R7 pulse ends", {30'd0, resp_valid, req_ready}, 32'd1);
  endtask

  task automatic t_reset;
    logic [31:0] pa; logic [2:0] c; int cy;
    chk("R10 ready", 32'(req_ready), 32'd1);
    chk("R10 resp_valid", 32'(resp_valid), 32'd0);
    chk("R10 mem_req_valid", 32'(mem_req_valid), 32'd0);
    xlate(32'h0000_0000, 1'b0, 1'b0, pa, c, cy);
    chk("R10 length 0 fault", 32'(c), 32'd1);
    chk("R10 no read", rd_q.size(), 32'd0);
  endtask

  task automatic t_basic;
    logic [31:0] pa; logic [2:0] c; int cy;
    xlate(32'h0010_17A5, 1'b0, 1'b0, pa, c, cy);
    chk("R1 code", 32'(c), 32'd0);
    chk("R1 paddr", pa, 32'h00AB_C7A5);
    chk("R2 read count", rd_q.size(), 32'd2);
    if (rd_q.size() == 2) begin
      chk("R2 outer addr", rd_q[0], 32'h0001_0004);
      chk("R2 inner addr", rd_q[1], 32'h0002_0014);
    end
    chk("R8 latency no stall", 32'(cy), 32'd5);
  endtask

  task automatic t_edges;
    logic [31:0] pa; logic [2:0] c; int cy;
    xlate(32'h007F_FFFF, 1'b1, 1'b0, pa, c, cy);
    chk("R1 top index paddr", pa, 32'hFFFF_FFFF);
    chk("R2 top inner addr", (rd_q.size() == 2) ? rd_q[1] : 32'hX, 32'h0003_0FFC);
    xlate(32'h0080_0000, 1'b0, 1'b0, pa, c, cy);
    chk("R3 length fault code", 32'(c), 32'd1);
    chk("R3 no read", rd_q.size(), 32'd0);
    chk("R11 fault paddr", pa, 32'd0);
  endtask

  task automatic t_faults;
    logic [31:0] pa; logic [2:0] c; int cy;
    xlate(32'h0020_0400, 1'b0, 1'b0, pa, c, cy);
    chk("R4 absent outer code", 32'(c), 32'd2);
    chk("R4 one read", rd_q.size(), 32'd1);
    xlate(32'h0030_0000, 1'b0, 1'b0, pa, c, cy);
    chk("R4 clear valid outer code", 32'(c), 32'd2);
    xlate(32'h0010_1C00, 1'b0, 1'b0, pa, c, cy);
    chk("R5 inner invalid code", 32'(c), 32'd3);
    chk("R5 two reads", rd_q.size(), 32'd2);
    chk("R11 inner fault paddr", pa, 32'd0);
  endtask

  task automatic t_perm;
    logic [31:0] pa; logic [2:0] c; int cy;
    xlate(32'h0010_1811, 1'b0, 1'b0, pa, c, cy);
    chk("R6 read of read-only code", 32'(c), 32'd0);
    chk("R6 read of read-only paddr", pa, 32'h0005_5811);
    xlate(32'h0010_1811, 1'b1, 1'b0, pa, c, cy);
    chk("R6 write to read-only code", 32'(c), 32'd4);
    chk("R11 protection paddr", pa, 32'd0);
    xlate(32'h0010_17A5, 1'b1, 1'b0, pa, c, cy);
    chk("R6 write to writable code", 32'(c), 32'd0);
  endtask

  task automatic t_slow_mem;
    logic [31:0] pa; logic [2:0] c; int cy;
    stall_cfg = 2; lat_cfg = 3;
    xlate(32'h0010_17A5, 1'b0, 1'b0, pa, c, cy);
    chk("R8 slow paddr", pa, 32'h00AB_C7A5);
    chk("R8 slow latency", 32'(cy), 32'd15);
    chk("R8 slow read count", rd_q.size(), 32'd2);
    stall_cfg = 0; lat_cfg = 0;
  endtask

  task automatic t_cfg_midwalk;
    logic [31:0] pa; logic [2:0] c; int cy;
    xlate(32'h0010_17A5, 1'b0, 1'b1, pa, c, cy);
    chk("R9 walk unaffected", pa, 32'h00AB_C7A5);
    chk("R9 walk outer addr", (rd_q.size() > 0) ? rd_q[0] : 32'hX, 32'h0001_0004);
    xlate(32'h0010_17A5, 1'b0, 1'b0, pa, c, cy);
    chk("R9 new length applies", 32'(c), 32'd1);
    cfg_write(1'b1, 32'd8);
    xlate(32'h0000_0000, 1'b0, 1'b0, pa, c, cy);
    chk("R9 new base applies", (rd_q.size() > 0) ? rd_q[0] : 32'hX, 32'h0009_0000);
    cfg_write(1'b0, 32'h0001_0000);
  endtask

  initial begin
    tbl[32'h0001_0004] = 32'h0002_0001;
    tbl[32'h0002_0014] = 32'h00AB_C403;
    tbl[32'h0002_0018] = 32'h0005_5801;
    tbl[32'h0001_000C] = 32'h0003_0000;
    tbl[32'h0001_001C] = 32'h0003_0001;
    tbl[32'h0003_0FFC] = 32'hFFFF_FC03;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    cfg_write(1'b0, 32'h0001_0000);
    cfg_write(1'b1, 32'd8);
    t_basic();
    t_edges();
    t_faults();
    t_perm();
    t_slow_mem();
    t_cfg_midwalk();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule